// File: doc/BRIEF.md
# Field Memory Power-Up Initialization Sequencer

This controller brings a dual-port serial field memory into a known state after power-up. The memory's write and read address pointers hold no meaningful value when power is applied. Before the memory is used, each port needs a run of dummy serial clock pulses and a pointer-reset strobe. The controller waits until the supply has been reported good for at least the stabilization interval. It then issues this sequence on both ports at once and raises a ready flag when the pointers can be trusted.

Two modes are supported. In the normal mode, each port receives the dummy clock run followed by one pointer reset. The recovery mode is meant for a system where cycling may have begun before the supply settled. In that mode, each port's dummy run is enclosed between two pointer resets. The stabilization interval is counted in system clocks. Its length is worked out from the clock-frequency parameter and rounded up. The dummy run length is a parameter, and elaboration rejects a value below 80.

Top module: `fieldmem_init_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all five outputs are low.
- R2: No clock enable or strobe is asserted until `supply_ok` has been sampled high on WAIT consecutive clock edges, where WAIT = ceil(CLK_HZ * STAB_US / 1e6). One low sample restarts the count.
- R3: In normal mode, the cycle after the wait completes starts exactly DUMMY_CYCLES consecutive clock-enable cycles. These are followed directly by one strobe cycle.
- R4: The write-side and read-side outputs run the same sequence in the same cycles.
- R5: In recovery mode, each port receives a single strobe cycle, then DUMMY_CYCLES clock-enable cycles, then a second strobe cycle, with no idle cycles between them.
- R6: Each strobe lasts exactly one cycle. It is never asserted in the same cycle as the clock enable of its own port.
- R7: `ready` rises in the cycle after the final strobe and stays high until reset. While `ready` is high, no clock enable or strobe is asserted.
- R8: The mode is sampled on the edge at which the wait completes. After that edge, changes on `recover_mode` or `supply_ok` have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply reported within range |
| recover_mode | input | 1 | 1 selects the bracketed-reset recovery sequence |
| wclk_en | output | 1 | Write serial clock enable (one pulse per cycle) |
| rclk_en | output | 1 | Read serial clock enable |
| wrst_p | output | 1 | Write pointer reset strobe |
| rrst_p | output | 1 | Read pointer reset strobe |
| ready | output | 1 | Pointers initialized |

## Verification
Two functions can fall in the same cycle: completion of the stabilization wait and a change of the inputs that the wait depends on. The bench provokes this by dropping `supply_ok` and flipping `recover_mode` in the middle of the dummy run. It also interrupts the wait once, one sample short of the midpoint. A behavioural model builds the expected output stream from a queue, starting when the consecutive-high count reaches WAIT. The bench judges the outputs against that model on every cycle. It then counts the pulses and strobes for each scenario.

// File: rtl/fieldmem_init_seq.sv
module fieldmem_init_seq #(
  parameter longint unsigned CLK_HZ       = 250_000_000,
  parameter longint unsigned STAB_US      = 100,
  parameter int unsigned     DUMMY_CYCLES = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic recover_mode,
  output logic wclk_en,
  output logic rclk_en,
  output logic wrst_p,
  output logic rrst_p,
  output logic ready
);
  localparam longint unsigned WAIT_CYC = (CLK_HZ * STAB_US + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned DUMMY_L  = 64'(DUMMY_CYCLES);
  localparam longint unsigned MAXC     = (WAIT_CYC > DUMMY_L) ? WAIT_CYC : DUMMY_L;
  localparam int              CW       = $clog2(MAXC + 1);
  localparam logic [CW-1:0]   WAIT_LAST  = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0]   WAIT_FULL  = CW'(WAIT_CYC);
  localparam logic [CW-1:0]   DUMMY_LAST = CW'(DUMMY_L - 1);

  if (DUMMY_CYCLES < 80) begin : g_bad_dummy
    $error("DUMMY_CYCLES must be at least 80");
  end

  typedef enum logic [2:0] {S_WAIT, S_RST1, S_CYC, S_RST2, S_DONE} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      S_WAIT:
        if (!supply_ok) cnt_nx = '0;
        else if (cnt == WAIT_LAST) begin
          cnt_nx = '0;
          st_nx  = recover_mode ? S_RST1 : S_CYC;
        end else cnt_nx = cnt + CW'(1);
      S_RST1: st_nx = S_CYC;
      S_CYC:
        if (cnt == DUMMY_LAST) begin
          cnt_nx = '0;
          st_nx  = S_RST2;
        end else cnt_nx = cnt + CW'(1);
      S_RST2: st_nx = S_DONE;
      default: st_nx = S_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_WAIT;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end

  assign wclk_en = (st == S_CYC);
  assign rclk_en = (st == S_CYC);
  assign wrst_p  = (st == S_RST1) || (st == S_RST2);
  assign rrst_p  = (st == S_RST1) || (st == S_RST2);
  assign ready   = (st == S_DONE);

  // Checker state: consecutive supply-good run and dummy pulses since the last strobe.
  logic [CW-1:0] chk_sup_run;
  logic          chk_seen;
  logic [CW-1:0] chk_clk_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chk_sup_run <= '0;
      chk_seen    <= 1'b0;
      chk_clk_run <= '0;
    end else begin
      if (!supply_ok) chk_sup_run <= '0;
      else if (chk_sup_run < WAIT_FULL) chk_sup_run <= chk_sup_run + CW'(1);
      chk_seen <= chk_seen || (chk_sup_run == WAIT_FULL);
      if (wrst_p) chk_clk_run <= '0;
      else if (wclk_en) chk_clk_run <= chk_clk_run + CW'(1);
    end

  assert_wait_before_activity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_en || wrst_p || rclk_en || rrst_p) |-> (chk_seen || chk_sup_run == WAIT_FULL));

  assert_dummy_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrst_p && $past(wclk_en)) |-> (chk_clk_run == CW'(DUMMY_L)));

  assert_ports_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_en == rclk_en) && (wrst_p == rrst_p));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrst_p |=> !wrst_p);

  assert_strobe_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrst_p && wclk_en) && !(rrst_p && rclk_en));

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_ready_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(wrst_p) && $past(rrst_p)));

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !(wclk_en || rclk_en || wrst_p || rrst_p));
endmodule

// File: tb/fieldmem_init_seq_tb.sv
module fieldmem_init_seq_tb_top;
  localparam int WAITN = 25000;  // ceil(250e6 * 100 / 1e6)
  localparam int DUMMY = 80;

  logic clk = 1'b0;
  logic rst_n, supply_ok, recover_mode;
  logic wclk_en, rclk_en, wrst_p, rrst_p, ready;

  always #2 clk = ~clk;

  fieldmem_init_seq dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .recover_mode(recover_mode),
    .wclk_en(wclk_en), .rclk_en(rclk_en), .wrst_p(wrst_p), .rrst_p(rrst_p), .ready(ready)
  );

  int tests = 0, fails = 0, cyc = 0;
  string ctag = "R2";

  // Behavioural reference: {wclk, rclk, wrst, rrst} stream queued when the wait ends.
  logic [3:0] q[$];
  int run = 0;
  bit started = 0, done_m = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); run = 0; started = 0; done_m = 0;
    end else if (!started) begin
      if (supply_ok) run++; else run = 0;
      if (run == WAITN) begin
        started = 1;
        if (recover_mode) q.push_back(4'b0011);
        repeat (DUMMY) q.push_back(4'b1100);
        q.push_back(4'b0011);
      end
    end else if (q.size() > 0) begin
      void'(q.pop_front());
      if (q.size() == 0) done_m = 1;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  int n_wclk = 0, n_rclk = 0, n_wrst = 0, n_rrst = 0;

  always @(negedge clk) if (rst_n) begin
    logic [3:0] e;
    string t;
    e = (started && q.size() > 0) ? q[0] : 4'b0000;
    t = started ? ctag : "R2";
    check(t, "wclk_en", int'(wclk_en), int'(e[3]));
    check(t, "rclk_en", int'(rclk_en), int'(e[2]));
    check("R6", "wrst_p", int'(wrst_p), int'(e[1]));
    check("R6", "rrst_p", int'(rrst_p), int'(e[0]));
    check("R7", "ready", int'(ready), int'(done_m));
    check("R4", "port match", int'({wclk_en, wrst_p}), int'({rclk_en, rrst_p}));
    n_wclk += int'(wclk_en); n_rclk += int'(rclk_en);
    n_wrst += int'(wrst_p);  n_rrst += int'(rrst_p);
  end

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      finish_up();
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check("R1", "outputs in reset", int'({wclk_en, rclk_en, wrst_p, rrst_p, ready}), 0);
    rst_n = 1'b1;
    n_wclk = 0; n_rclk = 0; n_wrst = 0; n_rrst = 0;
    @(negedge clk);
    check("R1", "outputs after reset", int'({wclk_en, rclk_en, wrst_p, rrst_p, ready}), 0);
  endtask

  task automatic wait_ready();
    int k = 0;
    while (!ready && k < 40000) begin @(negedge clk); k++; end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; recover_mode = 1'b0;
    // Scenario A: normal mode, an interrupted wait, input changes mid-sequence (R2, R3, R8)
    do_reset();
    ctag = "R2";
    repeat (40) @(negedge clk);
    supply_ok = 1'b1;
    repeat (12499) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    ctag = "R3";
    wait (started);
    ctag = "R8";
    repeat (30) @(negedge clk);
    recover_mode = 1'b1; supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    recover_mode = 1'b0; supply_ok = 1'b1;
    wait_ready();
    check("R3", "write clock pulses", n_wclk, DUMMY);
    check("R3", "read clock pulses", n_rclk, DUMMY);
    check("R3", "write strobes", n_wrst, 1);
    check("R4", "read strobes", n_rrst, 1);
    check("R7", "ready held", int'(ready), 1);

    // Scenario B: recovery mode with bracketed strobes (R5)
    recover_mode = 1'b1;
    do_reset();
    ctag = "R5";
    wait_ready();
    check("R5", "write clock pulses", n_wclk, DUMMY);
    check("R5", "read clock pulses", n_rclk, DUMMY);
    check("R5", "write strobes", n_wrst, 2);
    check("R5", "read strobes", n_rrst, 2);
    check("R7", "ready held", int'(ready), 1);
    finish_up();
  end
endmodule